// File: doc/BRIEF.md
# Exception, Interrupt and Break Entry Sequencer

This block computes the architectural state change a small 32-bit RISC core makes when it enters a handler. The core has a branch delay slot and an immediate-prefix instruction. Each cycle it sees the current program counter, the machine status word, the syndrome word, the delay-slot, immediate-pending and prefixed-branch flags, and the pending branch target. It also sees five kinds of request: external interrupt, hardware exception, memory-management fault, hardware break and software break. At most one request is accepted per cycle.

For an accepted entry the block registers, on the next clock edge, the new program counter, the new status word and the syndrome, fault-address and branch-target register values, each with its own write strobe. It also produces one register-file write (index and data) for the return address, a strobe that clears the core's delay-slot and immediate flags, a strobe that drops the load-reserve reservation, and a one-cycle done pulse that carries the event class. Decode, translation lookup and the register file itself live elsewhere.

Top module: `exc_entry_unit`

## Requirements
- R1: An interrupt request is accepted only when status bit IE (bit 1) is 1, bits EIP (bit 9) and BIP (bit 3) are 0, and neither the delay-slot flag nor the immediate-pending flag is set; otherwise it has no effect and no strobe rises.
- R2: When several requests coincide, only one entry is taken, in this order: memory fault, hardware exception, hardware break, software break, interrupt.
- R3: Every entry copies UM (bit 11) into UMS (bit 12) and VM (bit 13) into VMS (bit 14), then clears UM and VM. An interrupt entry also clears IE. Other status bits are kept unless a rule below sets them.
- R4: The new PC is VEC_BASE+0x10 for an interrupt, VEC_BASE+0x20 for a hardware exception or memory fault, VEC_BASE+0x18 for a hardware break, and the branch target for a software break.
- R5: An interrupt writes the PC to register 14. A hardware break writes the PC to register 16 and sets BIP. A software break sets BIP and writes no register.
- R6: A hardware exception writes PC+4 to register 17, sets EIP, and writes a syndrome equal to the incoming syndrome with bit 12 replaced by the delay-slot flag. When that flag is set, the branch-target register is loaded with the pending branch target.
- R7: With parameter EXC_EN = 0 a hardware exception request is ignored: no entry is taken for it, and a lower-priority request in the same cycle is served instead.
- R8: A memory fault writes to register 17 the PC minus an adjustment and sets EIP. The adjustment is 8 in a delay slot after a prefixed branch, 4 in any other delay slot, 4 outside a delay slot when the immediate-pending flag is set, and 0 otherwise.
- R9: A memory fault writes the fault address to the fault-address register and writes the syndrome fresh. Bits 4..0 hold 16 + 2·miss + fetch, where access kind 2 is fetch, 1 is store and 0 is load. Bit 10 is set for a store, and bit 12 holds the delay-slot flag. In a delay slot the branch-target register is loaded.
- R10: The flag-clear strobe rises for hardware exceptions and memory faults only. The reservation-clear strobe and the done pulse rise for every entry, in the cycle after the request. The class reads 1 for interrupt, 2 for hardware exception, 3 for memory fault, 4 for hardware break and 5 for software break.
- R11: While rst_n is low at a clock edge, every strobe and the done pulse are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 32 | Current program counter |
| msr_i | input | 32 | Current machine status word |
| esr_i | input | 32 | Current syndrome word |
| in_dslot_i | input | 1 | Current instruction sits in a delay slot |
| imm_pend_i | input | 1 | Immediate prefix pending |
| br_imm_i | input | 1 | Pending branch was immediate-prefixed |
| br_target_i | input | 32 | Pending branch target |
| irq_i | input | 1 | External interrupt request |
| hwexc_req_i | input | 1 | Hardware exception request |
| mmu_req_i | input | 1 | Memory fault request |
| mmu_miss_i | input | 1 | 1 = translation miss, 0 = protection fault |
| mmu_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| mmu_addr_i | input | 32 | Faulting address |
| hwbrk_req_i | input | 1 | Hardware break request |
| swbrk_req_i | input | 1 | Software break request |
| pc_we_o | output | 1 | PC write strobe |
| pc_o | output | 32 | New PC |
| msr_we_o | output | 1 | Status write strobe |
| msr_o | output | 32 | New status word |
| esr_we_o | output | 1 | Syndrome write strobe |
| esr_o | output | 32 | New syndrome |
| ear_we_o | output | 1 | Fault-address write strobe |
| ear_o | output | 32 | Fault address |
| btr_we_o | output | 1 | Branch-target register write strobe |
| btr_o | output | 32 | Saved branch target |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_addr_o | output | 5 | Register index |
| rf_data_o | output | 32 | Return address |
| flags_clr_o | output | 1 | Clear delay-slot and immediate flags |
| resv_clr_o | output | 1 | Drop load-reserve reservation |
| entry_done_o | output | 1 | One-cycle entry pulse |
| entry_class_o | output | 3 | Class of the entry taken |

## Verification
The embedded properties check, on every cycle, several rules. An accepted interrupt always had a qualifying status word and clear flags. A memory-fault request always wins. Every status write moves VM and UM into their saved positions. The flag-clear strobe appears only with exception classes. The branch-target register is written only with syndrome bit 12 set. The store bit always tracks the access kind. The exact vector addresses, the return-address arithmetic for each delay-slot and prefix combination, the syndrome codes, and the behaviour with exception support configured off are shown only by the bench's scenarios.

// File: rtl/exc_entry_pkg.sv
// Shared definitions for the exception entry unit: event classes, status
// word bit positions, return-register indices and vector offsets.
// Assumes a 32-bit status word whose saved-mode bits sit one above the live ones.
package exc_entry_pkg;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_IRQ   = 3'd1,
        EV_HWEXC = 3'd2,
        EV_MMU   = 3'd3,
        EV_HWBRK = 3'd4,
        EV_SWBRK = 3'd5
    } ev_class_e;

    localparam int ST_IE  = 1;
    localparam int ST_BIP = 3;
    localparam int ST_EIP = 9;
    localparam int ST_UM  = 11;
    localparam int ST_VM  = 13;
    localparam int N_MODE = 2;

    localparam int SYN_DS    = 12;
    localparam int SYN_STORE = 10;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic [4:0] RA_IRQ = 5'd14;
    localparam logic [4:0] RA_BRK = 5'd16;
    localparam logic [4:0] RA_EXC = 5'd17;

    localparam int VOFS_IRQ = 'h10;
    localparam int VOFS_BRK = 'h18;
    localparam int VOFS_EXC = 'h20;

endpackage

// File: rtl/exc_arbiter.sv
// Selects the single event taken this cycle.
// Assumes requests are level signals sampled in the same cycle as the status word.
// Fixed order: memory fault, hardware exception, hardware break, software break, interrupt.
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter bit EXC_EN = 1'b1
) (
    input  logic [XLEN-1:0] msr_i,
    input  logic            in_dslot_i,
    input  logic            imm_pend_i,
    input  logic            irq_i,
    input  logic            hwexc_req_i,
    input  logic            mmu_req_i,
    input  logic            hwbrk_req_i,
    input  logic            swbrk_req_i,
    output ev_class_e       cls_o
);

    logic hwexc_ok;
    logic irq_ok;

    // Gate the hardware exception request by the build-time option.
    generate
        if (EXC_EN) begin : g_exc_on
            assign hwexc_ok = hwexc_req_i;
        end else begin : g_exc_off
            assign hwexc_ok = 1'b0;
        end
    endgenerate

    // Interrupt is only accepted in a quiet, enabled state.
    assign irq_ok = irq_i && msr_i[ST_IE] && !msr_i[ST_EIP] && !msr_i[ST_BIP]
                    && !in_dslot_i && !imm_pend_i;

    // Priority pick.
    always_comb begin
        if (mmu_req_i)        cls_o = EV_MMU;
        else if (hwexc_ok)    cls_o = EV_HWEXC;
        else if (hwbrk_req_i) cls_o = EV_HWBRK;
        else if (swbrk_req_i) cls_o = EV_SWBRK;
        else if (irq_ok)      cls_o = EV_IRQ;
        else                  cls_o = EV_NONE;
    end

endmodule

// File: rtl/exc_msr_update.sv
// Computes the status word written on handler entry.
// Assumes each saved-mode bit sits one position above its live bit.
module exc_msr_update
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ev_class_e       cls_i,
    input  logic [XLEN-1:0] msr_i,
    output logic [XLEN-1:0] msr_o
);

    localparam int MODE_POS [N_MODE] = '{ST_UM, ST_VM};

    logic [XLEN-1:0] saved;

    // Shift each live mode bit into its saved slot and clear the live bit.
    generate
        for (genvar k = 0; k < N_MODE; k++) begin : g_mode
            if (k == 0) begin : g_first
                always_comb begin
                    saved = msr_i;
                    for (int j = 0; j < N_MODE; j++) begin
                        saved[MODE_POS[j] + 1] = msr_i[MODE_POS[j]];
                        saved[MODE_POS[j]]     = 1'b0;
                    end
                end
            end
        end
    endgenerate

    // Apply class-specific enable and in-progress bits.
    always_comb begin
        msr_o = saved;
        case (cls_i)
            EV_IRQ:             msr_o[ST_IE]  = 1'b0;
            EV_HWEXC, EV_MMU:   msr_o[ST_EIP] = 1'b1;
            EV_HWBRK, EV_SWBRK: msr_o[ST_BIP] = 1'b1;
            default:            msr_o = msr_i;
        endcase
    end

endmodule

// File: rtl/exc_syndrome.sv
// Computes target PC, return-address write, syndrome and side strobes for the
// chosen event. Purely combinational; the top registers the results.
module exc_syndrome
    import exc_entry_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          RF_AW    = 5,
    parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
    input  ev_class_e         cls_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   esr_i,
    input  logic              in_dslot_i,
    input  logic              imm_pend_i,
    input  logic              br_imm_i,
    input  logic              mmu_miss_i,
    input  logic [1:0]        mmu_kind_i,
    output logic [XLEN-1:0]   pc_o,
    output logic              rf_we_o,
    output logic [RF_AW-1:0]  rf_addr_o,
    output logic [XLEN-1:0]   rf_data_o,
    output logic [XLEN-1:0]   esr_o,
    output logic              esr_we_o,
    output logic              ear_we_o,
    output logic              btr_we_o,
    output logic              flags_clr_o
);

    localparam logic [XLEN-1:0] VB = XLEN'(VEC_BASE);

    logic [XLEN-1:0] rewind;
    logic            is_fetch;
    logic            is_store;

    // Return-address rewind for a faulting access.
    always_comb begin
        if (in_dslot_i)      rewind = br_imm_i ? XLEN'(8) : XLEN'(4);
        else if (imm_pend_i) rewind = XLEN'(4);
        else                 rewind = '0;
    end

    assign is_fetch = (mmu_kind_i == ACC_FETCH);
    assign is_store = (mmu_kind_i == ACC_STORE);

    // Per-class outputs.
    always_comb begin
        pc_o        = '0;
        rf_we_o     = 1'b0;
        rf_addr_o   = '0;
        rf_data_o   = '0;
        esr_o       = esr_i;
        esr_we_o    = 1'b0;
        ear_we_o    = 1'b0;
        btr_we_o    = 1'b0;
        flags_clr_o = 1'b0;
        case (cls_i)
            EV_IRQ: begin
                pc_o      = VB + XLEN'(VOFS_IRQ);
                rf_we_o   = 1'b1;
                rf_addr_o = RF_AW'(RA_IRQ);
                rf_data_o = pc_i;
            end
            EV_HWEXC: begin
                pc_o          = VB + XLEN'(VOFS_EXC);
                rf_we_o       = 1'b1;
                rf_addr_o     = RF_AW'(RA_EXC);
                rf_data_o     = pc_i + XLEN'(4);
                esr_o[SYN_DS] = in_dslot_i;
                esr_we_o      = 1'b1;
                btr_we_o      = in_dslot_i;
                flags_clr_o   = 1'b1;
            end
            EV_MMU: begin
                pc_o             = VB + XLEN'(VOFS_EXC);
                rf_we_o          = 1'b1;
                rf_addr_o        = RF_AW'(RA_EXC);
                rf_data_o        = pc_i - rewind;
                esr_o            = '0;
                esr_o[4]         = 1'b1;
                esr_o[1]         = mmu_miss_i;
                esr_o[0]         = is_fetch;
                esr_o[SYN_STORE] = is_store;
                esr_o[SYN_DS]    = in_dslot_i;
                esr_we_o         = 1'b1;
                ear_we_o         = 1'b1;
                btr_we_o         = in_dslot_i;
                flags_clr_o      = 1'b1;
            end
            EV_HWBRK: begin
                pc_o      = VB + XLEN'(VOFS_BRK);
                rf_we_o   = 1'b1;
                rf_addr_o = RF_AW'(RA_BRK);
                rf_data_o = pc_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_entry_unit.sv
// Top of the handler entry sequencer. Picks one event per cycle, computes the
// architectural updates and registers them with one-cycle write strobes.
// Assumes the core holds its inputs stable for the request cycle and applies
// the strobes on the following cycle. SW break targets the branch target input.
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          RF_AW    = 5,
    parameter logic [31:0] VEC_BASE = 32'h0000_0100,
    parameter bit          EXC_EN   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [XLEN-1:0]  msr_i,
    input  logic [XLEN-1:0]  esr_i,
    input  logic             in_dslot_i,
    input  logic             imm_pend_i,
    input  logic             br_imm_i,
    input  logic [XLEN-1:0]  br_target_i,
    input  logic             irq_i,
    input  logic             hwexc_req_i,
    input  logic             mmu_req_i,
    input  logic             mmu_miss_i,
    input  logic [1:0]       mmu_kind_i,
    input  logic [XLEN-1:0]  mmu_addr_i,
    input  logic             hwbrk_req_i,
    input  logic             swbrk_req_i,
    output logic             pc_we_o,
    output logic [XLEN-1:0]  pc_o,
    output logic             msr_we_o,
    output logic [XLEN-1:0]  msr_o,
    output logic             esr_we_o,
    output logic [XLEN-1:0]  esr_o,
    output logic             ear_we_o,
    output logic [XLEN-1:0]  ear_o,
    output logic             btr_we_o,
    output logic [XLEN-1:0]  btr_o,
    output logic             rf_we_o,
    output logic [RF_AW-1:0] rf_addr_o,
    output logic [XLEN-1:0]  rf_data_o,
    output logic             flags_clr_o,
    output logic             resv_clr_o,
    output logic             entry_done_o,
    output logic [2:0]       entry_class_o
);

    ev_class_e         cls;
    logic [XLEN-1:0]   msr_n;
    logic [XLEN-1:0]   pc_n;
    logic [XLEN-1:0]   esr_n;
    logic [XLEN-1:0]   rf_data_n;
    logic [RF_AW-1:0]  rf_addr_n;
    logic              rf_we_n, esr_we_n, ear_we_n, btr_we_n, fclr_n;
    logic              take;

    exc_arbiter #(.XLEN(XLEN), .EXC_EN(EXC_EN)) u_arb (
        .msr_i      (msr_i),
        .in_dslot_i (in_dslot_i),
        .imm_pend_i (imm_pend_i),
        .irq_i      (irq_i),
        .hwexc_req_i(hwexc_req_i),
        .mmu_req_i  (mmu_req_i),
        .hwbrk_req_i(hwbrk_req_i),
        .swbrk_req_i(swbrk_req_i),
        .cls_o      (cls)
    );

    exc_msr_update #(.XLEN(XLEN)) u_msr (
        .cls_i(cls),
        .msr_i(msr_i),
        .msr_o(msr_n)
    );

    exc_syndrome #(.XLEN(XLEN), .RF_AW(RF_AW), .VEC_BASE(VEC_BASE)) u_syn (
        .cls_i      (cls),
        .pc_i       (pc_i),
        .esr_i      (esr_i),
        .in_dslot_i (in_dslot_i),
        .imm_pend_i (imm_pend_i),
        .br_imm_i   (br_imm_i),
        .mmu_miss_i (mmu_miss_i),
        .mmu_kind_i (mmu_kind_i),
        .pc_o       (),
        .rf_we_o    (rf_we_n),
        .rf_addr_o  (rf_addr_n),
        .rf_data_o  (rf_data_n),
        .esr_o      (esr_n),
        .esr_we_o   (esr_we_n),
        .ear_we_o   (ear_we_n),
        .btr_we_o   (btr_we_n),
        .flags_clr_o(fclr_n)
    );

    assign take = (cls != EV_NONE);

    // Software break jumps to the branch target; all others use the vector.
    logic [XLEN-1:0] pc_vec;
    exc_syndrome #(.XLEN(XLEN), .RF_AW(RF_AW), .VEC_BASE(VEC_BASE)) u_vec (
        .cls_i      (cls),
        .pc_i       (pc_i),
        .esr_i      (esr_i),
        .in_dslot_i (in_dslot_i),
        .imm_pend_i (imm_pend_i),
        .br_imm_i   (br_imm_i),
        .mmu_miss_i (mmu_miss_i),
        .mmu_kind_i (mmu_kind_i),
        .pc_o       (pc_vec),
        .rf_we_o    (),
        .rf_addr_o  (),
        .rf_data_o  (),
        .esr_o      (),
        .esr_we_o   (),
        .ear_we_o   (),
        .btr_we_o   (),
        .flags_clr_o()
    );
    assign pc_n = (cls == EV_SWBRK) ? br_target_i : pc_vec;

    // Register the entry results; strobes last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_we_o       <= 1'b0;
            pc_o          <= '0;
            msr_we_o      <= 1'b0;
            msr_o         <= '0;
            esr_we_o      <= 1'b0;
            esr_o         <= '0;
            ear_we_o      <= 1'b0;
            ear_o         <= '0;
            btr_we_o      <= 1'b0;
            btr_o         <= '0;
            rf_we_o       <= 1'b0;
            rf_addr_o     <= '0;
            rf_data_o     <= '0;
            flags_clr_o   <= 1'b0;
            resv_clr_o    <= 1'b0;
            entry_done_o  <= 1'b0;
            entry_class_o <= EV_NONE;
        end else begin
            pc_we_o       <= take;
            pc_o          <= pc_n;
            msr_we_o      <= take;
            msr_o         <= msr_n;
            esr_we_o      <= esr_we_n;
            esr_o         <= esr_n;
            ear_we_o      <= ear_we_n;
            ear_o         <= mmu_addr_i;
            btr_we_o      <= btr_we_n;
            btr_o         <= br_target_i;
            rf_we_o       <= rf_we_n;
            rf_addr_o     <= rf_addr_n;
            rf_data_o     <= rf_data_n;
            flags_clr_o   <= fclr_n;
            resv_clr_o    <= take;
            entry_done_o  <= take;
            entry_class_o <= cls;
        end
    end

    AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_done_o && entry_class_o == EV_IRQ) |->
        ($past(msr_i[ST_IE]) && !$past(msr_i[ST_EIP]) && !$past(msr_i[ST_BIP])
         && !$past(in_dslot_i) && !$past(imm_pend_i)));                      // R1
    AST_MMU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mmu_req_i)) |-> (entry_done_o && entry_class_o == EV_MMU)); // R2
    AST_MODE_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        msr_we_o |-> (msr_o[ST_VM + 1] == $past(msr_i[ST_VM]) && !msr_o[ST_VM]
                      && msr_o[ST_UM + 1] == $past(msr_i[ST_UM]) && !msr_o[ST_UM])); // R3
    AST_FLAGS_CLR_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        flags_clr_o |-> (entry_class_o == EV_HWEXC || entry_class_o == EV_MMU));  // R10
    AST_BTR_DSLOT: assert property (@(posedge clk) disable iff (!rst_n)
        btr_we_o |-> (esr_we_o && esr_o[SYN_DS]));                                // R6
    AST_STORE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_done_o && entry_class_o == EV_MMU) |->
        (esr_o[SYN_STORE] == ($past(mmu_kind_i) == ACC_STORE)));                  // R9

endmodule

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;
    import exc_entry_pkg::*;

    localparam logic [31:0] PC  = 32'h0000_1000;
    localparam logic [31:0] BT  = 32'h0000_2000;
    localparam logic [31:0] ESI = 32'h0000_1005;
    localparam logic [31:0] FA  = 32'hDEAD_0000;

    typedef struct packed {
        logic [4:0]  req;   // {mmu, hwexc, hwbrk, swbrk, irq}
        logic [31:0] msr;
        logic        ds;
        logic        imm;
        logic        bimm;
        logic        miss;
        logic [1:0]  kind;
        logic [2:0]  cls;
        logic [31:0] epc;
        logic [4:0]  rfa;   // 0 = no write expected
        logic [31:0] rfd;
        logic [31:0] emsr;
        logic [31:0] eesr;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{5'b00001, 32'h2802, 1'b0,1'b0,1'b0,1'b0,2'd0, 3'd1, 32'h110, 5'd14, 32'h1000, 32'h5000, 32'h0},
        '{5'b00001, 32'h0202, 1'b0,1'b0,1'b0,1'b0,2'd0, 3'd0, 32'h0,   5'd0,  32'h0,    32'h0,    32'h0},
        '{5'b00001, 32'h0002, 1'b1,1'b0,1'b0,1'b0,2'd0, 3'd0, 32'h0,   5'd0,  32'h0,    32'h0,    32'h0},
        '{5'b00001, 32'h000A, 1'b0,1'b0,1'b0,1'b0,2'd0, 3'd0, 32'h0,   5'd0,  32'h0,    32'h0,    32'h0},
        '{5'b00001, 32'h0002, 1'b0,1'b1,1'b0,1'b0,2'd0, 3'd0, 32'h0,   5'd0,  32'h0,    32'h0,    32'h0},
        '{5'b01000, 32'h2000, 1'b0,1'b0,1'b0,1'b0,2'd0, 3'd2, 32'h120, 5'd17, 32'h1004, 32'h4200, 32'h0005},
        '{5'b01000, 32'h0800, 1'b1,1'b0,1'b0,1'b0,2'd0, 3'd2, 32'h120, 5'd17, 32'h1004, 32'h1200, 32'h1005},
        '{5'b10000, 32'h0000, 1'b0,1'b0,1'b0,1'b0,2'd0, 3'd3, 32'h120, 5'd17, 32'h1000, 32'h0200, 32'h0010},
        '{5'b10000, 32'h0000, 1'b0,1'b0,1'b0,1'b0,2'd2, 3'd3, 32'h120, 5'd17, 32'h1000, 32'h0200, 32'h0011},
        '{5'b10000, 32'h0000, 1'b1,1'b0,1'b1,1'b1,2'd1, 3'd3, 32'h120, 5'd17, 32'h0FF8, 32'h0200, 32'h1412},
        '{5'b10000, 32'h0000, 1'b1,1'b0,1'b0,1'b1,2'd2, 3'd3, 32'h120, 5'd17, 32'h0FFC, 32'h0200, 32'h1013},
        '{5'b10000, 32'h0000, 1'b0,1'b1,1'b0,1'b1,2'd0, 3'd3, 32'h120, 5'd17, 32'h0FFC, 32'h0200, 32'h0012},
        '{5'b00100, 32'h2802, 1'b0,1'b0,1'b0,1'b0,2'd0, 3'd4, 32'h118, 5'd16, 32'h1000, 32'h500A, 32'h0},
        '{5'b00010, 32'h0000, 1'b0,1'b0,1'b0,1'b0,2'd0, 3'd5, 32'h2000,5'd0,  32'h0,    32'h0008, 32'h0},
        '{5'b11111, 32'h0002, 1'b0,1'b0,1'b0,1'b0,2'd0, 3'd3, 32'h120, 5'd17, 32'h1000, 32'h0202, 32'h0010},
        '{5'b01111, 32'h0002, 1'b0,1'b0,1'b0,1'b0,2'd0, 3'd2, 32'h120, 5'd17, 32'h1004, 32'h0202, 32'h0005},
        '{5'b00111, 32'h0002, 1'b0,1'b0,1'b0,1'b0,2'd0, 3'd4, 32'h118, 5'd16, 32'h1000, 32'h000A, 32'h0},
        '{5'b00011, 32'h0002, 1'b0,1'b0,1'b0,1'b0,2'd0, 3'd5, 32'h2000,5'd0,  32'h0,    32'h000A, 32'h0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [31:0] msr_i = '0;
    logic ds = 1'b0, imm = 1'b0, bimm = 1'b0, miss = 1'b0;
    logic [1:0] kind = 2'd0;
    logic irq = 1'b0, hx = 1'b0, mr = 1'b0, hb = 1'b0, sb = 1'b0;

    logic        pc_we, msr_we, esr_we, ear_we, btr_we, rf_we, fclr, rclr, done;
    logic [31:0] pc_o, msr_o, esr_o, ear_o, btr_o, rf_d;
    logic [4:0]  rf_a;
    logic [2:0]  cls_o;

    logic        n_pc_we, n_msr_we, n_esr_we, n_ear_we, n_btr_we, n_rf_we, n_fclr, n_rclr, n_done;
    logic [31:0] n_pc_o, n_msr_o, n_esr_o, n_ear_o, n_btr_o, n_rf_d;
    logic [4:0]  n_rf_a;
    logic [2:0]  n_cls_o;

    exc_entry_unit #(.VEC_BASE(32'h100), .EXC_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .pc_i(PC), .msr_i(msr_i), .esr_i(ESI),
        .in_dslot_i(ds), .imm_pend_i(imm), .br_imm_i(bimm), .br_target_i(BT),
        .irq_i(irq), .hwexc_req_i(hx), .mmu_req_i(mr), .mmu_miss_i(miss),
        .mmu_kind_i(kind), .mmu_addr_i(FA), .hwbrk_req_i(hb), .swbrk_req_i(sb),
        .pc_we_o(pc_we), .pc_o(pc_o), .msr_we_o(msr_we), .msr_o(msr_o),
        .esr_we_o(esr_we), .esr_o(esr_o), .ear_we_o(ear_we), .ear_o(ear_o),
        .btr_we_o(btr_we), .btr_o(btr_o), .rf_we_o(rf_we), .rf_addr_o(rf_a),
        .rf_data_o(rf_d), .flags_clr_o(fclr), .resv_clr_o(rclr),
        .entry_done_o(done), .entry_class_o(cls_o)
    );

    exc_entry_unit #(.VEC_BASE(32'h100), .EXC_EN(1'b0)) dut_noexc (
        .clk(clk), .rst_n(rst_n), .pc_i(PC), .msr_i(msr_i), .esr_i(ESI),
        .in_dslot_i(ds), .imm_pend_i(imm), .br_imm_i(bimm), .br_target_i(BT),
        .irq_i(irq), .hwexc_req_i(hx), .mmu_req_i(mr), .mmu_miss_i(miss),
        .mmu_kind_i(kind), .mmu_addr_i(FA), .hwbrk_req_i(hb), .swbrk_req_i(sb),
        .pc_we_o(n_pc_we), .pc_o(n_pc_o), .msr_we_o(n_msr_we), .msr_o(n_msr_o),
        .esr_we_o(n_esr_we), .esr_o(n_esr_o), .ear_we_o(n_ear_we), .ear_o(n_ear_o),
        .btr_we_o(n_btr_we), .btr_o(n_btr_o), .rf_we_o(n_rf_we), .rf_addr_o(n_rf_a),
        .rf_data_o(n_rf_d), .flags_clr_o(n_fclr), .resv_clr_o(n_rclr),
        .entry_done_o(n_done), .entry_class_o(n_cls_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] r);
        {mr, hx, hb, sb, irq} = r;
    endtask

    // Apply one request cycle and move to the sampling point after the edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        drive(5'b0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R11: reset holds every strobe low even with requests present
        drive(5'b11111); msr_i = 32'h2;
        @(posedge clk); @(negedge clk);
        chk("R11 done in reset", {31'b0, done}, 32'h0);
        chk("R11 strobes in reset", {23'b0, pc_we, msr_we, esr_we, ear_we, btr_we, rf_we, fclr, rclr, n_done}, 32'h0);
        drive(5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", {31'b0, done}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            bit   exc_cls;
            v = TBL[i];
            msr_i = v.msr; ds = v.ds; imm = v.imm; bimm = v.bimm;
            miss = v.miss; kind = v.kind;
            drive(v.req);
            step();
            exc_cls = (v.cls == 3'd2) || (v.cls == 3'd3);
            chk($sformatf("R1 R2 R10 class row %0d", i), {29'b0, cls_o}, {29'b0, v.cls});
            chk($sformatf("R10 done/resv row %0d", i), {30'b0, done, rclr},
                {30'b0, v.cls != 3'd0, v.cls != 3'd0});
            if (v.cls != 3'd0) begin
                chk($sformatf("R4 pc row %0d", i), pc_o, v.epc);
                chk($sformatf("R3 msr row %0d", i), msr_o, v.emsr);
                chk($sformatf("R5 R6 R8 rf we row %0d", i), {31'b0, rf_we}, {31'b0, v.rfa != 5'd0});
                if (v.rfa != 5'd0) begin
                    chk($sformatf("R5 R6 R8 rf addr row %0d", i), {27'b0, rf_a}, {27'b0, v.rfa});
                    chk($sformatf("R5 R6 R8 rf data row %0d", i), rf_d, v.rfd);
                end
                chk($sformatf("R10 flags clear row %0d", i), {31'b0, fclr}, {31'b0, exc_cls});
                chk($sformatf("R6 R9 esr we row %0d", i), {31'b0, esr_we}, {31'b0, exc_cls});
                if (exc_cls) chk($sformatf("R6 R9 esr row %0d", i), esr_o, v.eesr);
                chk($sformatf("R6 R9 btr we row %0d", i), {31'b0, btr_we}, {31'b0, exc_cls && v.ds});
                if (exc_cls && v.ds) chk($sformatf("R6 R9 btr row %0d", i), btr_o, BT);
                chk($sformatf("R9 ear we row %0d", i), {31'b0, ear_we}, {31'b0, v.cls == 3'd3});
                if (v.cls == 3'd3) chk($sformatf("R9 ear row %0d", i), ear_o, FA);
            end else begin
                chk($sformatf("R1 no strobes row %0d", i), {28'b0, pc_we, msr_we, rf_we, rclr}, 32'h0);
            end
            @(negedge clk);
            chk($sformatf("R10 pulse ends row %0d", i), {31'b0, done}, 32'h0);
        end

        // R7: exception support off ignores the request entirely
        msr_i = 32'h0; ds = 1'b0; imm = 1'b0; bimm = 1'b0;
        drive(5'b01000);
        step();
        chk("R7 ignored hwexc no entry", {28'b0, n_done, n_rf_we, n_msr_we, n_fclr}, 32'h0);
        chk("R7 enabled copy takes it", {29'b0, cls_o}, 32'd2);
        // R7: a lower-priority interrupt in the same cycle is served instead
        msr_i = 32'h2;
        drive(5'b01001);
        step();
        chk("R7 falls through to irq", {29'b0, n_cls_o}, 32'd1);
        chk("R7 irq return reg", {27'b0, n_rf_a}, 32'd14);
        chk("R2 hwexc over irq when enabled", {29'b0, cls_o}, 32'd2);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule